// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Set-on-Less-Than

This block is a 32-bit integer arithmetic and logic unit. It is built from a chain of identical one-bit slices, and each slice holds a full adder and a four-way output selector. The final slice is a special version that also produces the sign-compare bit and the signed overflow. The carry ripples from the lowest slice to the highest. A subtract reuses the same adder: one control line inverts every B bit and also forces the carry into the lowest slice to 1.

A 3-bit operation code picks the function: bitwise AND, bitwise OR, add, subtract or set-on-less-than. The top-level wrapper clears the result of unused codes. It also registers the result, the Zero flag and the Overflow flag, so every answer appears one clock after its operands are presented. This suits a pipelined execute stage. A subtract with Zero high tells an equal/not-equal branch that the operands match.

Top module: `alu_ripple_top`

## Requirements
- R1: Code 3'b000 gives result = a AND b, bit by bit.
- R2: Code 3'b001 gives result = a OR b, bit by bit.
- R3: Code 3'b010 gives result = (a + b) mod 2^32.
- R4: Code 3'b110 gives result = (a - b) mod 2^32, formed as a + ~b + 1.
- R5: Code 3'b111 gives result bit 0 = bit 31 of (a - b) mod 2^32, with no overflow correction, and result bits 31..1 = 0. When the subtraction overflows, this bit can be wrong as a signed comparison.
- R6: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R7: For codes 3'b010 and 3'b110, ovf_o is 1 when the carry into bit 31 differs from the carry out of bit 31, which is signed overflow. For every other code, ovf_o is 0.
- R8: The unused codes 3'b011, 3'b100 and 3'b101 give result 0, zero_o = 1 and ovf_o = 0, whatever the operands.
- R9: While rst is high at a rising edge, the outputs become result_o = 0, zero_o = 1 and ovf_o = 0.
- R10: The outputs at each rising edge reflect the operands and code sampled at that edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered all-zero flag |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
A broken carry link shows up as a wrong sum or difference in the very next cycle. It only shows for operand pairs that carry through that slice, so the bench uses operands near all-ones and near the sign boundary. A wrong feedback path from the sign bit to slice 0 shows up only under set-on-less-than, as a wrong bit 0. A wrong overflow tap shows up only when the signs of the operands and the sum disagree. Every fault appears one clock after the operands are presented and is compared on that cycle.

// File: rtl/alu_rip_pkg.sv
package alu_rip_pkg;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_rip_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       binv,
  input  logic       cin,
  input  logic       less,
  input  logic [1:0] sel,
  output logic       res,
  output logic       cout
);
  logic bx;
  logic sum;

  assign bx   = b ^ binv;
  assign sum  = a ^ bx ^ cin;
  assign cout = (bx & cin) | (a & cin) | (a & bx);

  always_comb begin
    unique case (sel)
      SEL_AND: res = a & bx;
      SEL_OR:  res = a | bx;
      SEL_SUM: res = sum;
      default: res = less;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_rip_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       binv,
  input  logic       cin,
  input  logic       less,
  input  logic [1:0] sel,
  output logic       res,
  output logic       set,
  output logic       ovf
);
  logic bx;
  logic sum;
  logic cout;

  assign bx   = b ^ binv;
  assign sum  = a ^ bx ^ cin;
  assign cout = (bx & cin) | (a & cin) | (a & bx);
  assign set  = sum;
  assign ovf  = cin ^ cout;

  always_comb begin
    unique case (sel)
      SEL_AND: res = a & bx;
      SEL_OR:  res = a | bx;
      SEL_SUM: res = sum;
      default: res = less;
    endcase
  end
endmodule

// File: rtl/alu_ripple_core.sv
module alu_ripple_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         binv,
  input  logic [1:0]   sel,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int LAST = W - 1;

  logic [LAST:0] carry;
  logic          set_bit;

  assign carry[0] = binv;

  for (genvar i = 0; i < LAST; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_mid
      assign less_in = 1'b0;
    end
    alu_bit_slice u_slice (
      .a    (a[i]),
      .b    (b[i]),
      .binv (binv),
      .cin  (carry[i]),
      .less (less_in),
      .sel  (sel),
      .res  (res[i]),
      .cout (carry[i+1])
    );
  end

  alu_msb_slice u_msb (
    .a    (a[LAST]),
    .b    (b[LAST]),
    .binv (binv),
    .cin  (carry[LAST]),
    .less (1'b0),
    .sel  (sel),
    .res  (res[LAST]),
    .set  (set_bit),
    .ovf  (ovf)
  );
endmodule

// File: rtl/alu_ripple_top.sv
module alu_ripple_top
  import alu_rip_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);
  logic [W-1:0] core_res;
  logic         core_ovf;
  logic         op_known;
  logic         op_arith;
  logic [W-1:0] res_d;
  logic [2:0]   op_q;

  alu_ripple_core #(.W(W)) u_core (
    .a    (a_i),
    .b    (b_i),
    .binv (op_i[2]),
    .sel  (op_i[1:0]),
    .res  (core_res),
    .ovf  (core_ovf)
  );

  assign op_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign op_known = op_arith || (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_SLT);
  assign res_d    = op_known ? core_res : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
      op_q     <= OP_AND;
    end else begin
      result_o <= res_d;
      zero_o   <= ~(|res_d);
      ovf_o    <= op_arith & core_ovf;
      op_q     <= op_i;
    end
  end

  assert_add_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (result_o == $past(a_i + b_i)));

  assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB) |=> (result_o == $past(a_i - b_i)));

  assert_slt_high_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_SLT) |-> (result_o[W-1:1] == '0));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (|result_o) |-> !zero_o);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !((op_q == OP_ADD) || (op_q == OP_SUB)) |-> !ovf_o);

  assert_unused_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'b011) || (op_i == 3'b100) || (op_i == 3'b101)) |=> (result_o == '0 && zero_o));

  assert_reset_state_R9: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && zero_o && !ovf_o));
endmodule

// File: tb/sim_alu_ripple_top.sv
module sim_alu_ripple_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [2:0]  op_i = 3'b000;
  logic [31:0] result_o;
  logic        zero_o;
  logic        ovf_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu_ripple_top #(.W(32)) u0 (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] r, input logic z, input logic v,
                       input logic [31:0] er, input logic ez, input logic ev);
    n_cmp++;
    if (r !== er || z !== ez || v !== ev) begin
      n_bad++;
      $display("FAIL %s: got res=%h zero=%b ovf=%b, expected res=%h zero=%b ovf=%b",
               req, r, z, v, er, ez, ev);
    end
  endtask

  // One cycle: drive at negedge, compare one edge later (R10)
  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    logic [31:0] er;
    logic [32:0] wide;
    logic        ev;
    ev = 1'b0;
    case (op)
      3'b000: er = a & b;                        // R1
      3'b001: er = a | b;                        // R2
      3'b010: begin                              // R3, R7
        wide = {1'b0, a} + {1'b0, b};
        er = wide[31:0];
        ev = (a[31] == b[31]) && (er[31] != a[31]);
      end
      3'b110: begin                              // R4, R7
        er = a - b;
        ev = (a[31] != b[31]) && (er[31] != a[31]);
      end
      3'b111: begin                              // R5 raw sign
        wide[31:0] = a - b;
        er = {31'b0, wide[31]};
      end
      default: er = '0;                          // R8
    endcase
    a_i = a; b_i = b; op_i = op;
    @(negedge clk);
    check(req_of(op), result_o, zero_o, ovf_o, er, (er == 0), ev);  // R6 via zero expectation
  endtask

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF;

    // R9: reset state with live operands
    a_i = 32'h1234_5678; b_i = 32'h1111_1111; op_i = 3'b010;
    repeat (3) @(negedge clk);
    check("R9", result_o, zero_o, ovf_o, 32'h0, 1'b1, 1'b0);
    rst = 1'b0;

    // Explicit corners
    step(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);  // R7 add overflow
    step(32'h8000_0000, 32'h0000_0001, 3'b110);  // R7 sub overflow
    step(32'h8000_0000, 32'h0000_0001, 3'b111);  // R5 wrong sign on overflow -> 0
    step(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);  // R3 wrap, zero R6
    step(32'h0000_0005, 32'h0000_0005, 3'b110);  // R4 equal, zero R6
    step(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);  // R5 -1 < 0
    step(32'hDEAD_BEEF, 32'hFFFF_FFFF, 3'b100);  // R8
    step(32'hDEAD_BEEF, 32'h0000_0000, 3'b011);  // R8
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b101);  // R8

    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          step(corner[i], corner[j], op[2:0]);

    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 200; k++)
        step($urandom, $urandom, op[2:0]);

    // R9 again mid-run
    rst = 1'b1;
    a_i = 32'h7FFF_FFFF; b_i = 32'h1; op_i = 3'b010;
    @(negedge clk);
    check("R9", result_o, zero_o, ovf_o, 32'h0, 1'b1, 1'b0);
    rst = 1'b0;
    step(32'h0000_0003, 32'h0000_0004, 3'b111);  // R5 3<4

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule